// File: doc/BRIEF.md
# TDM Serial Channel Deserializer

This block takes one serial time-division-multiplexed data line running at 32.768 Mbps and turns it into whole channel bytes. Each byte comes out with its channel number. The line is sampled in the system clock domain on every cycle where a bit-rate qualifier is high. An 8 kHz frame pulse marks the start of each frame. A frame carries 512 channels of 8 bits, which is 4096 bits per 125 us.

A mode input selects between two bus conventions:

- **Mode 0:** the frame pulse is active-low and each channel arrives most-significant bit first.
- **Mode 1:** the frame pulse is active-high and each channel arrives least-significant bit first.

Completed bytes leave on a registered byte/index/strobe interface. A flag marks channel 0. A framing-error flag reports a frame pulse that does not fall on a frame boundary. In a switching fabric this block sits at the front of each input port, where it feeds a per-channel store.

Top module: `tdm_rx_deser`

## Requirements
- R1: While reset is high, and in the first cycle after it, `ch_valid`, `frame_start` and `frame_err` are 0, and `ch_data` and `ch_idx` are 0.
- R2: A frame is 512 channels of 8 bits, and the 4096 qualified bits of a frame are numbered 0 to 4095. `ch_valid` is high for exactly one cycle: the cycle after the qualified cycle that carries the eighth bit of a channel. In that cycle `ch_idx` holds the channel number, and channel numbers rise by one per channel from 0 to 511.
- R3: With `bus_mode` = 0, the first bit received in a channel lands in `ch_data[7]` and the eighth lands in `ch_data[0]`.
- R4: With `bus_mode` = 1, the first bit received in a channel lands in `ch_data[0]` and the eighth lands in `ch_data[7]`.
- R5: The frame pulse is active when `fp_in` = 0 in mode 0, and when `fp_in` = 1 in mode 1. A frame starts at a qualified cycle where the pulse is active and was inactive at the previous qualified cycle. The bit sampled in that cycle is the first bit of channel 0.
- R6: `frame_start` is high only together with `ch_valid`, and only for channel 0.
- R7: With no further frame pulse, the bit position wraps from 4095 to 0. Channel 511 is followed by channel 0, `frame_start` is set, and `frame_err` stays 0.
- R8: Once framed, a frame start that arrives at a bit position other than 0 does four things. The channel in progress is dropped, with no `ch_valid` for it. Counting restarts at channel 0. `frame_err` rises in the next cycle. `frame_err` stays high until a frame start arrives exactly at bit position 0.
- R9: Cycles with `bit_en` = 0 neither sample `sdata` nor advance the bit position. No `ch_valid` is produced before the first frame start after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-rate qualifier; sample `sdata` and `fp_in` this cycle |
| bus_mode | input | 1 | 0: active-low pulse, MSB first; 1: active-high pulse, LSB first |
| fp_in | input | 1 | Frame pulse, polarity chosen by `bus_mode` |
| sdata | input | 1 | Serial TDM data |
| ch_valid | output | 1 | One-cycle strobe for a completed channel |
| ch_data | output | 8 | Completed channel byte |
| ch_idx | output | 9 | Channel number of `ch_data` |
| frame_start | output | 1 | Set with `ch_valid` for channel 0 |
| frame_err | output | 1 | Misplaced frame pulse seen; cleared by an on-boundary pulse |

## Verification
The main function is driven with whole frames of channel-dependent byte patterns in both bus modes. Because the patterns are asymmetric, a swapped bit order or an off-by-one channel index shows up as a data or index mismatch. One mode runs with the qualifier high every cycle and the other with it high every third cycle. This separates sampling on the qualifier from sampling on the clock. A frame with no pulse checks the free wrap. A pulse three bits into a channel checks that the partial byte is dropped, that counting restarts, and that the error flag is set and later cleared by an on-time pulse. A stretch of traffic before any pulse checks that nothing is emitted while unframed.

// File: rtl/tdm_deser_pkg.sv
package tdm_deser_pkg;

  typedef enum logic {
    BUS_FALL_MSB = 1'b0,
    BUS_RISE_LSB = 1'b1
  } bus_mode_e;

  function automatic logic pulse_active(input logic raw, input logic mode);
    return (mode == BUS_RISE_LSB) ? raw : ~raw;
  endfunction

endpackage

// File: rtl/tdm_fp_detect.sv
module tdm_fp_detect
  import tdm_deser_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic bus_mode,
  input  logic fp_in,
  output logic frame_hit
);

  logic act_now;
  logic act_prev;

  assign act_now   = pulse_active(fp_in, bus_mode);
  assign frame_hit = bit_en && act_now && !act_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_prev <= 1'b0;
    end else if (bit_en) begin
      act_prev <= act_now;
    end
  end

  // R5: a held pulse yields a single frame start
  p_hit_once_r5: assert property (@(posedge clk) disable iff (rst)
    frame_hit |=> !frame_hit);

endmodule

// File: rtl/tdm_bit_counter.sv
module tdm_bit_counter #(
  parameter int FRAME_BITS = 4096,
  localparam int POS_W = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             frame_hit,
  output logic [POS_W-1:0] cur_pos,
  output logic             synced,
  output logic             frame_err
);

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

  logic [POS_W-1:0] cnt;

  assign cur_pos = frame_hit ? '0 : cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      synced    <= 1'b0;
      frame_err <= 1'b0;
    end else if (bit_en) begin
      cnt <= (cur_pos == LAST_POS) ? '0 : cur_pos + 1'b1;
      if (frame_hit) begin
        synced    <= 1'b1;
        frame_err <= synced && (cnt != '0);
      end
    end
  end

  // R7: free wrap at the end of a frame
  p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !frame_hit && cnt == LAST_POS) |=> (cnt == '0));

  // R8: a frame start restarts counting at position 0
  p_restart_r8: assert property (@(posedge clk) disable iff (rst)
    frame_hit |=> (cnt == POS_W'(1)));

  // R8: a misplaced pulse once framed raises the error flag
  p_err_set_r8: assert property (@(posedge clk) disable iff (rst)
    (frame_hit && synced && cnt != '0) |=> frame_err);

  // R8: the flag only clears on an on-boundary pulse
  p_err_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (frame_err && !frame_hit) |=> frame_err);

endmodule

// File: rtl/tdm_byte_shifter.sv
module tdm_byte_shifter
  import tdm_deser_pkg::*;
#(
  parameter int CH_BITS = 8,
  localparam int BIT_W = $clog2(CH_BITS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_en,
  input  logic               bus_mode,
  input  logic               sdata,
  input  logic [BIT_W-1:0]   bit_in_ch,
  output logic [CH_BITS-1:0] byte_next,
  output logic               last_bit
);

  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(CH_BITS - 1);

  logic [CH_BITS-1:0] sh;
  logic [CH_BITS-1:0] base;

  assign base     = (bit_in_ch == '0) ? '0 : sh;
  assign last_bit = bit_en && (bit_in_ch == LAST_BIT);

  always_comb begin
    if (bus_mode == BUS_RISE_LSB) begin
      byte_next = {sdata, base[CH_BITS-1:1]};
    end else begin
      byte_next = {base[CH_BITS-2:0], sdata};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '0;
    end else if (bit_en) begin
      sh <= byte_next;
    end
  end

  // R9: without a qualifier the partial byte is held
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(sh));

endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser
  import tdm_deser_pkg::*;
#(
  parameter int CH_BITS = 8,
  parameter int NUM_CH  = 512,
  localparam int FRAME_BITS = CH_BITS * NUM_CH,
  localparam int POS_W = $clog2(FRAME_BITS),
  localparam int BIT_W = $clog2(CH_BITS),
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_en,
  input  logic               bus_mode,
  input  logic               fp_in,
  input  logic               sdata,
  output logic               ch_valid,
  output logic [CH_BITS-1:0] ch_data,
  output logic [IDX_W-1:0]   ch_idx,
  output logic               frame_start,
  output logic               frame_err
);

  logic               frame_hit;
  logic [POS_W-1:0]   cur_pos;
  logic               synced;
  logic [CH_BITS-1:0] byte_next;
  logic               last_bit;
  logic [IDX_W-1:0]   idx_now;

  tdm_fp_detect u_fp (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .bus_mode  (bus_mode),
    .fp_in     (fp_in),
    .frame_hit (frame_hit)
  );

  tdm_bit_counter #(.FRAME_BITS(FRAME_BITS)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .frame_hit (frame_hit),
    .cur_pos   (cur_pos),
    .synced    (synced),
    .frame_err (frame_err)
  );

  tdm_byte_shifter #(.CH_BITS(CH_BITS)) u_sh (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .bus_mode  (bus_mode),
    .sdata     (sdata),
    .bit_in_ch (cur_pos[BIT_W-1:0]),
    .byte_next (byte_next),
    .last_bit  (last_bit)
  );

  assign idx_now = cur_pos[POS_W-1:BIT_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_valid    <= 1'b0;
      ch_data     <= '0;
      ch_idx      <= '0;
      frame_start <= 1'b0;
    end else begin
      ch_valid    <= last_bit && (synced || frame_hit);
      frame_start <= last_bit && (synced || frame_hit) && (idx_now == '0);
      if (last_bit) begin
        ch_data <= byte_next;
        ch_idx  <= idx_now;
      end
    end
  end

  // R2: the channel strobe is a single-cycle pulse
  p_valid_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    ch_valid |=> !ch_valid);

  // R6: frame start only accompanies a channel strobe
  p_fs_with_valid_r6: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (ch_valid && ch_idx == '0));

  // R9: nothing is emitted while unframed
  p_no_valid_unsynced_r9: assert property (@(posedge clk) disable iff (rst)
    ch_valid |-> synced);

endmodule

// File: tb/sim_tdm_rx_deser.sv
module sim_tdm_rx_deser;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b0;
  logic       bus_mode = 1'b0;
  logic       fp_in = 1'b1;
  logic       sdata = 1'b0;
  logic       ch_valid;
  logic [7:0] ch_data;
  logic [8:0] ch_idx;
  logic       frame_start;
  logic       frame_err;

  int checks = 0;
  int errors = 0;
  int gap = 0;
  int bad_valid, bad_data, bad_idx, bad_fs;

  always #4 clk = ~clk;

  tdm_rx_deser u0 (
    .clk(clk), .rst(rst), .bit_en(bit_en), .bus_mode(bus_mode),
    .fp_in(fp_in), .sdata(sdata), .ch_valid(ch_valid), .ch_data(ch_data),
    .ch_idx(ch_idx), .frame_start(frame_start), .frame_err(frame_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int ch);
    return 8'((ch * 29 + seed * 13) ^ (ch >> 3) ^ 8'hA5);
  endfunction

  function automatic logic idle_fp();
    return bus_mode ? 1'b0 : 1'b1;
  endfunction

  task automatic clear_bad();
    bad_valid = 0; bad_data = 0; bad_idx = 0; bad_fs = 0;
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst = 1'b1; bus_mode = mode; bit_en = 1'b0; sdata = 1'b0; fp_in = idle_fp();
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // Starts and ends right after a falling edge.
  task automatic bit_cycle(input logic b, input logic fp_on, output logic v,
                           output logic [7:0] d, output logic [8:0] i, output logic fs);
    sdata = b; bit_en = 1'b1;
    fp_in = fp_on ? ~idle_fp() : idle_fp();
    @(posedge clk);
    @(negedge clk);
    v = ch_valid; d = ch_data; i = ch_idx; fs = frame_start;
    bit_en = 1'b0; fp_in = idle_fp(); sdata = ~b;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      if (ch_valid) bad_valid++;
    end
  endtask

  task automatic send_channel(input logic [7:0] val, input logic fp_first,
                              input bit expect_out, input int exp_idx);
    logic v, fs;
    logic [7:0] d;
    logic [8:0] i;
    for (int k = 0; k < 8; k++) begin
      bit_cycle(bus_mode ? val[k] : val[7-k], fp_first && k == 0, v, d, i, fs);
      if (k < 7 || !expect_out) begin
        if (v) bad_valid++;
      end else begin
        if (!v) bad_valid++;
        if (d != val) bad_data++;
        if (int'(i) != exp_idx) bad_idx++;
        if (fs != (exp_idx == 0)) bad_fs++;
      end
    end
  endtask

  task automatic send_frame(input int seed, input logic with_fp);
    for (int c = 0; c < 512; c++) send_channel(pat(seed, c), with_fp && c == 0, 1'b1, c);
  endtask

  task automatic test_reset();
    do_reset(1'b0);
    check(ch_valid == 0 && frame_start == 0 && frame_err == 0, "R1 flags", int'(ch_valid), 0);
    check(ch_data == 0 && ch_idx == 0, "R1 data/idx", int'(ch_data), 0);
  endtask

  task automatic test_unframed();
    clear_bad();
    for (int c = 0; c < 4; c++) send_channel(pat(1, c), 1'b0, 1'b0, c);
    check(bad_valid == 0, "R9 no output before first pulse", bad_valid, 0);
  endtask

  task automatic test_msb_frames();
    clear_bad();
    send_frame(2, 1'b1);
    check(bad_valid == 0, "R2 strobe timing", bad_valid, 0);
    check(bad_idx == 0, "R2 channel index", bad_idx, 0);
    check(bad_data == 0, "R3 MSB-first data", bad_data, 0);
    check(bad_fs == 0, "R5/R6 frame start on channel 0", bad_fs, 0);
    clear_bad();
    send_frame(3, 1'b0);
    check(bad_idx == 0 && bad_fs == 0, "R7 wrap to channel 0", bad_idx + bad_fs, 0);
    check(bad_data == 0 && bad_valid == 0, "R7 data after wrap", bad_data + bad_valid, 0);
    check(frame_err == 1'b0, "R7 no error on wrap", int'(frame_err), 0);
  endtask

  task automatic test_misframe();
    logic v, fs;
    logic [7:0] d;
    logic [8:0] i;
    clear_bad();
    for (int c = 0; c < 100; c++) send_channel(pat(4, c), 1'b0, 1'b1, c);
    for (int k = 0; k < 3; k++) begin
      bit_cycle(1'b1, 1'b0, v, d, i, fs);
      if (v) bad_valid++;
    end
    send_channel(8'h3C, 1'b1, 1'b1, 0);
    check(bad_valid == 0, "R8 partial channel dropped", bad_valid, 0);
    check(bad_idx == 0 && bad_fs == 0 && bad_data == 0, "R8 restart at channel 0",
          bad_idx + bad_fs + bad_data, 0);
    check(frame_err == 1'b1, "R8 error flag set", int'(frame_err), 1);
    clear_bad();
    for (int c = 1; c < 512; c++) send_channel(pat(5, c), 1'b0, 1'b1, c);
    check(frame_err == 1'b1, "R8 error flag held", int'(frame_err), 1);
    send_channel(pat(6, 0), 1'b1, 1'b1, 0);
    check(frame_err == 1'b0, "R8 cleared by on-time pulse", int'(frame_err), 0);
    check(bad_idx == 0 && bad_data == 0 && bad_valid == 0, "R8 frame after restart",
          bad_idx + bad_data + bad_valid, 0);
  endtask

  task automatic test_lsb_sparse();
    do_reset(1'b1);
    gap = 2;
    clear_bad();
    send_frame(7, 1'b1);
    check(bad_data == 0, "R4 LSB-first data", bad_data, 0);
    check(bad_idx == 0 && bad_fs == 0, "R5 active-high pulse framing", bad_idx + bad_fs, 0);
    check(bad_valid == 0, "R9 qualifier gaps ignored", bad_valid, 0);
    clear_bad();
    send_channel(8'h01, 1'b1, 1'b1, 0);
    check(bad_data == 0 && frame_err == 0, "R4 single set bit / on-time pulse",
          bad_data + int'(frame_err), 0);
    gap = 0;
  endtask

  initial begin
    fork
      begin
        test_reset();
        test_unframed();
        test_msb_frames();
        test_misframe();
        test_lsb_sparse();
      end
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule